// File: doc/BRIEF.md
# Paired-Page TLB Translator

This block is a small, fully associative translation buffer for a 32-bit address space split into user, unmapped and mapped kernel segments. Each of its entries maps a pair of adjacent pages, one even and one odd, that share a tag. The tag is a virtual page number, a per-entry page mask, an address-space identifier and a global bit. Each half of the pair has its own frame number, valid bit and dirty bit. A request carries a virtual address, a log2 access size, the current identifier, a write flag, a fetch/data select and a kernel-mode flag. One cycle later the block returns either a physical address or a single fault code.

Entries are loaded one at a time by index through a write port. A separate probe port searches the tags for a given page number and identifier and reports the lowest matching index or a miss. Page-table walking, cache attributes and exception dispatch are left to the surrounding logic. The fault report gives that logic what it needs to refill or repair an entry: the address, the lookup page number, the identifier and whether the access was a data write.

Top module: `tlbx_pair_tlb`

## Requirements
- R1: An entry matches when the lookup page number and the stored page number agree in every bit that the entry's mask leaves clear, and either the entry's global bit is set or the request identifier equals the entry identifier.
- R2: A probe returns, one cycle after probe_valid, probe_done=1 with the lowest matching index and probe_miss=0, or probe_miss=1 with probe_idx=0 when no entry matches. The probe outputs hold between probes.
- R3: The lookup page number is the virtual address shifted right by 11 bits. Its two low bits are forced to zero unless small_pages is 1.
- R4: The virtual address bit at the entry's shift position picks the page. A 0 uses frame 0 with its valid and dirty bits, and a 1 uses frame 1 with its valid and dirty bits.
- R5: A mapped physical address is frame·4096 with every bit below the entry's shift cleared, ORed with the virtual address bits below that shift.
- R6: A mapped access whose address has any of its low req_size bits set (access of 2^req_size bytes) reports fault code 1 (address error). This takes priority over every other fault.
- R7: A mapped access that matches no entry reports fault code 2 (refill). The response carries the request address, the lookup page number, the identifier, and a write flag equal to req_write AND NOT req_fetch.
- R8: A matching access whose selected valid bit is 0 reports fault code 3 (invalid).
- R9: A data write (req_write=1, req_fetch=0) to a valid page whose selected dirty bit is 0 reports fault code 4 (modified). Fetches never report code 4.
- R10: Addresses with top bits 100 (kernel cached window) or 101 (kernel uncached window) bypass the buffer, and rsp_pa is the address with its top three bits cleared. A top-bits-100 access reports code 1 when req_kernel is 0 or it is misaligned. A top-bits-101 access never faults.
- R11: rsp_valid is 1 exactly in the cycle after req_valid. Fault code 0 means no fault, and with any nonzero code rsp_pa is 0. After reset all outputs are 0.
- R12: An entry write becomes visible to lookups and probes on the following cycle. A lookup in the same cycle as the write sees the old contents.
- R13: Reset clears every entry to all-zero fields, so a probe for page 0 with identifier 0 hits index 0 and a probe with a nonzero identifier misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_asid | input | 8 | Current address-space identifier |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_kernel | input | 1 | Requester runs in kernel mode |
| small_pages | input | 1 | Keep the two low lookup page-number bits |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 21 | Tag page number |
| wr_mask | input | 21 | Tag page mask (1 = ignore bit) |
| wr_asid | input | 8 | Tag identifier |
| wr_global | input | 1 | Tag matches any identifier |
| wr_shift | input | 5 | Page-size shift of the entry |
| wr_pfn0 | input | 24 | Even frame number |
| wr_pfn1 | input | 24 | Odd frame number |
| wr_v0 | input | 1 | Even page valid |
| wr_v1 | input | 1 | Odd page valid |
| wr_d0 | input | 1 | Even page writable |
| wr_d1 | input | 1 | Odd page writable |
| probe_valid | input | 1 | Probe strobe |
| probe_vpn | input | 21 | Probe page number |
| probe_asid | input | 8 | Probe identifier |
| rsp_valid | output | 1 | Translation result valid |
| rsp_fault | output | 3 | Fault code (0 none, 1 address, 2 refill, 3 invalid, 4 modified) |
| rsp_pa | output | 36 | Physical address |
| rsp_va | output | 32 | Echo of the request address |
| rsp_vpn | output | 21 | Lookup page number used |
| rsp_asid | output | 8 | Echo of the request identifier |
| rsp_write | output | 1 | Request was a data write |
| probe_done | output | 1 | Probe result valid |
| probe_miss | output | 1 | Probe found no entry |
| probe_idx | output | 4 | Lowest matching index |

## Verification
A lookup and an entry write can land in the same cycle, on the very entry the lookup hits. The bench provokes this by changing a valid page to invalid while translating an address in it, and then translating the same address again in the next cycle. The reference model judges the first response against the old table and the second against the new one, so a write that takes effect too early, or too late, shows up as a mismatch. A probe also runs in parallel with lookups, and both results are compared every cycle.

// File: rtl/tlbx_pkg.sv
`timescale 1ns/1ps
package tlbx_pkg;
    parameter int VA_W      = 32;
    parameter int ASID_W    = 8;
    parameter int PFN_W     = 24;
    parameter int SHIFT_W   = 5;
    parameter int PAGE_BITS = 12;
    parameter int VPN_LSB   = 11;
    localparam int VPN_W    = VA_W - VPN_LSB;
    localparam int PA_W     = PFN_W + PAGE_BITS;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ADDR     = 3'd1,
        FLT_REFILL   = 3'd2,
        FLT_INVALID  = 3'd3,
        FLT_MODIFIED = 3'd4
    } fault_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
    } key_t;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [PFN_W-1:0]   pfn0;
        logic [PFN_W-1:0]   pfn1;
        logic               v0;
        logic               v1;
        logic               d0;
        logic               d1;
    } data_t;
endpackage

// File: rtl/tlbx_store.sv
`timescale 1ns/1ps
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [IDX_W-1:0]       wr_idx_i,
    input  key_t                   wr_key_i,
    input  data_t                  wr_data_i,
    output key_t  [DEPTH-1:0]      keys_o,
    output data_t [DEPTH-1:0]      data_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                keys_o[g] <= '0;
                data_o[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                keys_o[g] <= wr_key_i;
                data_o[g] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/tlbx_match.sv
`timescale 1ns/1ps
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  key_t [DEPTH-1:0]   keys_i,
    input  logic [VPN_W-1:0]   vpn_i,
    input  logic [ASID_W-1:0]  asid_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [DEPTH-1:0] match_v;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic tag_eq;
        logic id_ok;
        assign tag_eq = (((vpn_i ^ keys_i[g].vpn) & ~keys_i[g].mask) == '0);
        assign id_ok  = keys_i[g].glob || (asid_i == keys_i[g].asid);
        assign match_v[g] = tag_eq && id_ok;
    end

    // lowest index wins: scan from the top so the last write is the lowest
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_v[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbx_xlate.sv
`timescale 1ns/1ps
module tlbx_xlate
    import tlbx_pkg::*;
(
    input  logic [VA_W-1:0] va_i,
    input  logic [1:0]      size_i,
    input  logic            write_i,
    input  logic            fetch_i,
    input  logic            kernel_i,
    input  logic            hit_i,
    input  data_t           data_i,
    output fault_e          fault_o,
    output logic [PA_W-1:0] pa_o
);
    localparam int SEG_LO = VA_W - 3;

    logic [VA_W-1:0] align_mask;
    logic            misaligned;
    logic            in_cached;
    logic            in_uncached;
    logic            odd_page;
    logic            page_valid;
    logic            page_dirty;
    logic [PA_W-1:0] off_mask;
    logic [PA_W-1:0] frame_base;
    logic [PA_W-1:0] mapped_pa;
    logic [PA_W-1:0] direct_pa;

    always_comb begin
        align_mask  = (VA_W'(1) << size_i) - VA_W'(1);
        misaligned  = |(va_i & align_mask);
        in_cached   = (va_i[VA_W-1 -: 3] == 3'b100);
        in_uncached = (va_i[VA_W-1 -: 3] == 3'b101);
        odd_page    = va_i[data_i.shift];
        page_valid  = odd_page ? data_i.v1 : data_i.v0;
        page_dirty  = odd_page ? data_i.d1 : data_i.d0;
        off_mask    = (PA_W'(1) << data_i.shift) - PA_W'(1);
        frame_base  = {(odd_page ? data_i.pfn1 : data_i.pfn0), {PAGE_BITS{1'b0}}};
        mapped_pa   = (frame_base & ~off_mask) | (PA_W'(va_i) & off_mask);
        direct_pa   = PA_W'(va_i[SEG_LO-1:0]);
    end

    // priority: address error, refill, invalid, modified
    always_comb begin
        fault_o = FLT_NONE;
        pa_o    = '0;
        if (in_cached) begin
            if (!kernel_i || misaligned) fault_o = FLT_ADDR;
            else                         pa_o    = direct_pa;
        end else if (in_uncached) begin
            pa_o = direct_pa;
        end else if (misaligned) begin
            fault_o = FLT_ADDR;
        end else if (!hit_i) begin
            fault_o = FLT_REFILL;
        end else if (!page_valid) begin
            fault_o = FLT_INVALID;
        end else if (write_i && !fetch_i && !page_dirty) begin
            fault_o = FLT_MODIFIED;
        end else begin
            pa_o = mapped_pa;
        end
    end
endmodule

// File: rtl/tlbx_pair_tlb.sv
`timescale 1ns/1ps
module tlbx_pair_tlb
    import tlbx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_size,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic               req_write,
    input  logic               req_fetch,
    input  logic               req_kernel,
    input  logic               small_pages,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [VPN_W-1:0]   wr_mask,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               wr_global,
    input  logic [SHIFT_W-1:0] wr_shift,
    input  logic [PFN_W-1:0]   wr_pfn0,
    input  logic [PFN_W-1:0]   wr_pfn1,
    input  logic               wr_v0,
    input  logic               wr_v1,
    input  logic               wr_d0,
    input  logic               wr_d1,
    input  logic               probe_valid,
    input  logic [VPN_W-1:0]   probe_vpn,
    input  logic [ASID_W-1:0]  probe_asid,
    output logic               rsp_valid,
    output logic [2:0]         rsp_fault,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [VA_W-1:0]    rsp_va,
    output logic [VPN_W-1:0]   rsp_vpn,
    output logic [ASID_W-1:0]  rsp_asid,
    output logic               rsp_write,
    output logic               probe_done,
    output logic               probe_miss,
    output logic [IDX_W-1:0]   probe_idx
);
    key_t  [DEPTH-1:0] keys;
    data_t [DEPTH-1:0] datas;
    key_t              wr_key;
    data_t             wr_data;
    logic [VPN_W-1:0]  lookup_vpn;
    logic              l_hit;
    logic [IDX_W-1:0]  l_idx;
    logic              p_hit;
    logic [IDX_W-1:0]  p_idx;
    fault_e            x_fault;
    logic [PA_W-1:0]   x_pa;
    fault_e            fault_q;

    assign wr_key  = '{vpn: wr_vpn, mask: wr_mask, asid: wr_asid, glob: wr_global};
    assign wr_data = '{shift: wr_shift, pfn0: wr_pfn0, pfn1: wr_pfn1,
                       v0: wr_v0, v1: wr_v1, d0: wr_d0, d1: wr_d1};

    assign lookup_vpn = small_pages ? req_va[VA_W-1:VPN_LSB]
                                    : {req_va[VA_W-1:VPN_LSB+2], 2'b00};

    tlbx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_key_i(wr_key), .wr_data_i(wr_data), .keys_o(keys), .data_o(datas)
    );

    tlbx_match #(.DEPTH(DEPTH)) u_lookup_match (
        .keys_i(keys), .vpn_i(lookup_vpn), .asid_i(req_asid),
        .hit_o(l_hit), .idx_o(l_idx)
    );

    tlbx_match #(.DEPTH(DEPTH)) u_probe_match (
        .keys_i(keys), .vpn_i(probe_vpn), .asid_i(probe_asid),
        .hit_o(p_hit), .idx_o(p_idx)
    );

    tlbx_xlate u_xlate (
        .va_i(req_va), .size_i(req_size), .write_i(req_write),
        .fetch_i(req_fetch), .kernel_i(req_kernel), .hit_i(l_hit),
        .data_i(datas[l_idx]), .fault_o(x_fault), .pa_o(x_pa)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            fault_q    <= FLT_NONE;
            rsp_pa     <= '0;
            rsp_va     <= '0;
            rsp_vpn    <= '0;
            rsp_asid   <= '0;
            rsp_write  <= 1'b0;
            probe_done <= 1'b0;
            probe_miss <= 1'b0;
            probe_idx  <= '0;
        end else begin
            rsp_valid  <= req_valid;
            probe_done <= probe_valid;
            if (req_valid) begin
                fault_q   <= x_fault;
                rsp_pa    <= x_pa;
                rsp_va    <= req_va;
                rsp_vpn   <= lookup_vpn;
                rsp_asid  <= req_asid;
                rsp_write <= req_write && !req_fetch;
            end
            if (probe_valid) begin
                probe_miss <= !p_hit;
                probe_idx  <= p_hit ? p_idx : '0;
            end
        end
    end

    assign rsp_fault = fault_q;

    // R11
    fault_clears_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault_q != FLT_NONE) |-> (rsp_pa == '0));

    // R11
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    fetch_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |=> (fault_q != FLT_MODIFIED));

    // R10
    uncached_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[VA_W-1 -: 3] == 3'b101) |=>
        (fault_q == FLT_NONE && rsp_pa == PA_W'($past(req_va[VA_W-4:0]))));

    // R6
    mapped_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[0] && req_size != 2'd0 && req_va[VA_W-1 -: 2] != 2'b10)
        |=> (fault_q == FLT_ADDR));

    // R2
    probe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |=> probe_done);
endmodule

// File: tb/sim_tlbx_pair_tlb.sv
`timescale 1ns/1ps
module sim_tlbx_pair_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_fetch = 0, req_kernel = 0, small_pages = 0;
    logic [31:0] req_va = 0;
    logic [1:0]  req_size = 0;
    logic [7:0]  req_asid = 0;
    logic        wr_en = 0, wr_global = 0, wr_v0 = 0, wr_v1 = 0, wr_d0 = 0, wr_d1 = 0;
    logic [3:0]  wr_idx = 0;
    logic [20:0] wr_vpn = 0, wr_mask = 0;
    logic [7:0]  wr_asid = 0;
    logic [4:0]  wr_shift = 0;
    logic [23:0] wr_pfn0 = 0, wr_pfn1 = 0;
    logic        probe_valid = 0;
    logic [20:0] probe_vpn = 0;
    logic [7:0]  probe_asid = 0;
    logic        rsp_valid, rsp_write, probe_done, probe_miss;
    logic [2:0]  rsp_fault;
    logic [35:0] rsp_pa;
    logic [31:0] rsp_va;
    logic [20:0] rsp_vpn;
    logic [7:0]  rsp_asid;
    logic [3:0]  probe_idx;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    tlbx_pair_tlb u0 (.*);

    // behavioural table
    logic [20:0] m_vpn [16];
    logic [20:0] m_mask [16];
    logic [7:0]  m_asid [16];
    logic        m_g [16];
    int          m_sh [16];
    longint      m_pfn0 [16];
    longint      m_pfn1 [16];
    bit          m_v0 [16], m_v1 [16], m_d0 [16], m_d1 [16];

    // expected outputs
    bit          e_valid = 0, e_write = 0, e_pdone = 0, e_pmiss = 0;
    int          e_fault = 0;
    logic [35:0] e_pa = 0;
    logic [31:0] e_va = 0;
    logic [20:0] e_vpn = 0;
    logic [7:0]  e_asid = 0;
    logic [3:0]  e_pidx = 0;

    function automatic int m_find(logic [20:0] v, logic [7:0] a);
        for (int i = 0; i < 16; i++)
            if (((v & ~m_mask[i]) == (m_vpn[i] & ~m_mask[i])) && (m_g[i] || m_asid[i] == a))
                return i;
        return -1;
    endfunction

    task automatic m_xlate(output int f, output longint pa, output logic [20:0] lv);
        longint va = longint'(req_va);
        longint algn = longint'(1) << req_size;
        bit mis = (va % algn) != 0;
        int top = int'(va >> 29);
        int hit;
        lv = small_pages ? req_va[31:11] : (req_va[31:11] & ~21'd3);
        f = 0; pa = 0;
        if (top == 4) begin
            if (!req_kernel || mis) f = 1; else pa = va % (longint'(1) << 29);
        end else if (top == 5) begin
            pa = va % (longint'(1) << 29);
        end else if (mis) begin
            f = 1;
        end else begin
            hit = m_find(lv, req_asid);
            if (hit < 0) f = 2;
            else begin
                longint span = longint'(1) << m_sh[hit];
                bit odd = ((va / span) % 2) == 1;
                longint pfn = odd ? m_pfn1[hit] : m_pfn0[hit];
                bit vld = odd ? m_v1[hit] : m_v0[hit];
                bit drt = odd ? m_d1[hit] : m_d0[hit];
                if (!vld) f = 3;
                else if (req_write && !req_fetch && !drt) f = 4;
                else pa = (pfn * 4096) / span * span + (va % span);
            end
        end
    endtask

    task automatic cycle(input string tag);
        int f = 0;
        longint pa = 0;
        logic [20:0] lv = 0;
        int pidx = -1;
        if (req_valid) m_xlate(f, pa, lv);
        if (probe_valid) pidx = m_find(probe_vpn, probe_asid);
        @(posedge clk);
        #1;
        e_valid = req_valid;
        if (req_valid) begin
            e_fault = f; e_pa = pa[35:0]; e_va = req_va; e_vpn = lv;
            e_asid = req_asid; e_write = req_write && !req_fetch;
        end
        e_pdone = probe_valid;
        if (probe_valid) begin
            e_pmiss = (pidx < 0);
            e_pidx = (pidx < 0) ? 4'd0 : pidx[3:0];
        end
        checks++;
        if ({rsp_valid, rsp_fault, rsp_pa, rsp_va, rsp_vpn, rsp_asid, rsp_write} !==
            {e_valid, e_fault[2:0], e_pa, e_va, e_vpn, e_asid, e_write}) begin
            errors++;
            $display("FAIL %s rsp: got v=%0d f=%0d pa=%h va=%h vpn=%h id=%h w=%0d exp v=%0d f=%0d pa=%h va=%h vpn=%h id=%h w=%0d",
                tag, rsp_valid, rsp_fault, rsp_pa, rsp_va, rsp_vpn, rsp_asid, rsp_write,
                e_valid, e_fault, e_pa, e_va, e_vpn, e_asid, e_write);
        end
        checks++;
        if ({probe_done, probe_miss, probe_idx} !== {e_pdone, e_pmiss, e_pidx}) begin
            errors++;
            $display("FAIL %s probe: got done=%0d miss=%0d idx=%0d exp done=%0d miss=%0d idx=%0d",
                tag, probe_done, probe_miss, probe_idx, e_pdone, e_pmiss, e_pidx);
        end
        if (wr_en) begin
            m_vpn[wr_idx] = wr_vpn; m_mask[wr_idx] = wr_mask; m_asid[wr_idx] = wr_asid;
            m_g[wr_idx] = wr_global; m_sh[wr_idx] = int'(wr_shift);
            m_pfn0[wr_idx] = longint'(wr_pfn0); m_pfn1[wr_idx] = longint'(wr_pfn1);
            m_v0[wr_idx] = wr_v0; m_v1[wr_idx] = wr_v1; m_d0[wr_idx] = wr_d0; m_d1[wr_idx] = wr_d1;
        end
        req_valid = 0; probe_valid = 0; wr_en = 0;
    endtask

    task automatic set_entry(input int idx, input logic [20:0] vpn, input logic [20:0] msk,
                             input logic [7:0] id, input bit g, input int sh,
                             input logic [23:0] p0, input logic [23:0] p1,
                             input bit v0, input bit v1, input bit d0, input bit d1);
        wr_en = 1; wr_idx = idx[3:0]; wr_vpn = vpn; wr_mask = msk; wr_asid = id;
        wr_global = g; wr_shift = sh[4:0]; wr_pfn0 = p0; wr_pfn1 = p1;
        wr_v0 = v0; wr_v1 = v1; wr_d0 = d0; wr_d1 = d1;
    endtask

    task automatic set_req(input logic [31:0] va, input int sz, input logic [7:0] id,
                           input bit wr, input bit fe, input bit kn);
        req_valid = 1; req_va = va; req_size = sz[1:0]; req_asid = id;
        req_write = wr; req_fetch = fe; req_kernel = kn;
    endtask

    task automatic set_probe(input logic [20:0] vpn, input logic [7:0] id);
        probe_valid = 1; probe_vpn = vpn; probe_asid = id;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vpn[i] = 0; m_mask[i] = 0; m_asid[i] = 0; m_g[i] = 0; m_sh[i] = 0;
            m_pfn0[i] = 0; m_pfn1[i] = 0; m_v0[i] = 0; m_v1[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 R13: outputs at zero after reset
        checks++;
        if ({rsp_valid, rsp_fault, rsp_pa, probe_done, probe_miss, probe_idx} !== '0) begin
            errors++;
            $display("FAIL R13 reset outputs: got v=%0d f=%0d pa=%h pd=%0d pm=%0d pi=%0d exp all 0",
                rsp_valid, rsp_fault, rsp_pa, probe_done, probe_miss, probe_idx);
        end
        set_probe(21'h0, 8'd0);               cycle("R13");
        set_probe(21'h0, 8'd5);               cycle("R13");
        // load table
        set_entry(0, 21'h800, 21'h0, 8'd5, 0, 12, 24'h100, 24'h101, 1, 1, 1, 0); cycle("R12");
        set_entry(1, 21'h1000, 21'hF, 8'd0, 1, 14, 24'h200, 24'h300, 1, 0, 1, 1); cycle("R12");
        set_entry(2, 21'h800, 21'h0, 8'd5, 0, 12, 24'h555, 24'h556, 1, 1, 1, 1); cycle("R12");
        set_entry(3, 21'h800, 21'h0, 8'd7, 0, 12, 24'h700, 24'h701, 1, 1, 1, 1); cycle("R12");
        set_entry(4, 21'h2001, 21'h0, 8'd0, 1, 10, 24'h400, 24'h401, 1, 1, 1, 1); cycle("R12");
        // probes
        set_probe(21'h800, 8'd5);             cycle("R2");
        set_probe(21'h800, 8'd7);             cycle("R1");
        set_probe(21'h1003, 8'd9);            cycle("R1");
        set_probe(21'h5555, 8'd3);            cycle("R2");
        // translations
        set_req(32'h0040_0010, 2, 8'd5, 0, 0, 0);  cycle("R5");
        set_req(32'h0040_1020, 2, 8'd5, 0, 0, 0);  cycle("R4");
        set_req(32'h0040_1020, 2, 8'd5, 1, 0, 0);  cycle("R9");
        set_req(32'h0040_1020, 2, 8'd5, 1, 1, 0);  cycle("R9");
        set_req(32'h0040_0010, 2, 8'd5, 1, 0, 0);  cycle("R9");
        set_req(32'h0040_0010, 2, 8'd9, 1, 0, 0);  cycle("R7");
        set_req(32'h0080_4008, 3, 8'd3, 0, 0, 0);  cycle("R8");
        set_req(32'h0080_2008, 3, 8'd3, 0, 0, 0);  cycle("R1");
        set_req(32'h0040_0012, 2, 8'd5, 0, 0, 0);  cycle("R6");
        set_req(32'h0700_0001, 1, 8'd5, 1, 0, 0);  cycle("R6");
        set_req(32'h0040_0013, 0, 8'd5, 0, 0, 0);  cycle("R6");
        small_pages = 1;
        set_req(32'h0100_0C10, 2, 8'd1, 0, 0, 0);  cycle("R3");
        small_pages = 0;
        set_req(32'h0100_0C10, 2, 8'd1, 0, 0, 0);  cycle("R3");
        set_req(32'h8000_1234, 0, 8'd0, 0, 0, 1);  cycle("R10");
        set_req(32'h8000_1234, 0, 8'd0, 0, 0, 0);  cycle("R10");
        set_req(32'h8000_1232, 2, 8'd0, 0, 0, 1);  cycle("R10");
        set_req(32'hA000_0042, 2, 8'd0, 1, 0, 0);  cycle("R10");
        set_req(32'hC000_0000, 2, 8'd0, 0, 1, 1);  cycle("R7");
        cycle("R11");
        // R12: lookup and write to the same entry in one cycle
        set_req(32'h0080_2008, 3, 8'd3, 0, 0, 0);
        set_entry(1, 21'h1000, 21'hF, 8'd0, 1, 14, 24'h200, 24'h300, 0, 0, 1, 1);
        set_probe(21'h1000, 8'd2);
        cycle("R12");
        set_req(32'h0080_2008, 3, 8'd3, 0, 0, 0);
        set_probe(21'h1000, 8'd2);
        cycle("R12");
        // reshape entry 0 to global and probe again
        set_entry(0, 21'h5554, 21'h3, 8'd0, 1, 12, 24'h10, 24'h11, 1, 1, 1, 1);
        set_probe(21'h5555, 8'd3);
        cycle("R12");
        set_probe(21'h5555, 8'd3);
        set_req(32'h02AA_A000, 2, 8'd3, 1, 0, 0);
        cycle("R2");
        cycle("R11");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule